// File: doc/BRIEF.md
# Address Space Quadrant Decoder

This block is the first stage of a 64-bit address translation unit. For every access it decides one of three things. The access may bypass translation in real mode. It may be sent on to the table walker with a fully qualified identity. Or it may be rejected because the address falls in a quadrant that cannot be used. The inputs are the effective address, a two-bit access kind, the instruction and data relocation enables, and the current partition and process identifiers.

The two most significant address bits select the quadrant. Quadrant 0 walks with the caller's process identifier. Quadrant 3 walks with process identifier 0, which is the operating-system space. Quadrants 1 and 2 raise a segment fault. For a data access, that fault also reports the faulting address. By default the outputs are registered. A registered valid strobe marks the cycle in which the status flags and payload apply.

Top module: `addr_quadrant_dec`

## Requirements
- R1: Real mode is selected when `access_i` is 2 (fetch) and `ir_en_i` is 0, or when `access_i` is 0 (read) or 1 (write) and `dr_en_i` is 0. In real mode `real_o` is 1 and the quadrant is not decoded.
- R2: In real mode, `real_addr_o` is `ea_i` with bits 63:60 cleared and `perm_o` is 3'b111 ({read, write, exec}). `virt_o` is 0, and `walk_ea_o`, `walk_part_o`, `walk_proc_o` and `fault_addr_o` are 0. Outside real mode, `real_addr_o` and `perm_o` are 0.
- R3: For a virtual access in quadrant 0 (ea bits 63:62 = 2'b00), `virt_o` is 1, `walk_part_o` equals `part_id_i` and `walk_proc_o` equals `proc_id_i`.
- R4: For a virtual access in quadrant 3 (ea bits 63:62 = 2'b11), `virt_o` is 1, `walk_part_o` equals `part_id_i` and `walk_proc_o` is 0.
- R5: For a virtual access in quadrant 1 or 2, `seg_fault_o` is 1 and `virt_o` is 0. `seg_instr_o` is 1 when the access is a fetch and 0 when it is a read or write.
- R6: `fault_addr_o` equals `ea_i` on a data segment fault and is 0 in every other case.
- R7: On a walk request, `walk_ea_o` is `ea_i` with bits 63:62 cleared. When there is no walk request, `walk_ea_o` is 0.
- R8: When `valid_o` is 1, exactly one of `real_o`, `virt_o` and `seg_fault_o` is 1. When `valid_o` is 0, all three flags are 0.
- R9: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge. `valid_o` follows `valid_i` with one cycle of delay. During reset every output is 0.
- R10: `access_i` must never be 3 while `valid_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access present |
| access_i | input | 2 | 0 read, 1 write, 2 fetch |
| ea_i | input | ADDR_W | Effective address |
| ir_en_i | input | 1 | Instruction relocation enable |
| dr_en_i | input | 1 | Data relocation enable |
| part_id_i | input | ID_W | Partition identifier |
| proc_id_i | input | ID_W | Process identifier |
| valid_o | output | 1 | Result valid |
| real_o | output | 1 | Real-mode result |
| virt_o | output | 1 | Walk request |
| seg_fault_o | output | 1 | Segment fault request |
| seg_instr_o | output | 1 | Fault is an instruction segment fault |
| perm_o | output | 3 | {read, write, exec} granted in real mode |
| real_addr_o | output | ADDR_W | Real address |
| fault_addr_o | output | ADDR_W | Faulting data address |
| walk_ea_o | output | ADDR_W | Address handed to the walker |
| walk_part_o | output | ID_W | Partition identifier for the walk |
| walk_proc_o | output | ID_W | Process identifier for the walk |

## Verification
The hardest case is one where the relocation enable that does not apply to the access kind differs from the one that does. For example, a fetch with data relocation off but instruction relocation on must still decode its quadrant. A design that looks at the wrong enable passes any stimulus where both enables agree. The stimulus therefore sweeps every access kind against all four enable pairs and all four quadrants. Each access carries distinct partition and process values, so a zeroed or swapped identifier is visible. Random cycles with idle gaps follow. They expose any leakage of a payload into a cycle where it should be zero.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    QD_USER  = 2'b00,
    QD_ILL_A = 2'b01,
    QD_ILL_B = 2'b10,
    QD_OS    = 2'b11
  } quad_e;

  localparam int unsigned REAL_CLR_BITS = 4;
  localparam int unsigned QUAD_BITS     = 2;
  localparam int unsigned PERM_W        = 3;
endpackage

// File: rtl/qd_mode_sel.sv
module qd_mode_sel
  import qd_pkg::*;
(
  input  logic [1:0] access_i,
  input  logic       ir_en_i,
  input  logic       dr_en_i,
  output logic       is_fetch_o,
  output logic       is_real_o
);
  assign is_fetch_o = (access_i == ACC_FETCH);
  assign is_real_o  = is_fetch_o ? ~ir_en_i : ~dr_en_i;
endmodule

// File: rtl/qd_quadrant.sv
module qd_quadrant
  import qd_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ID_W   = 32
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [ID_W-1:0]   part_id_i,
  input  logic [ID_W-1:0]   proc_id_i,
  output logic              legal_o,
  output logic [ID_W-1:0]   part_o,
  output logic [ID_W-1:0]   proc_o,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned LOW_W = ADDR_W - QUAD_BITS;

  quad_e quad;
  assign quad = quad_e'(ea_i[ADDR_W-1 -: QUAD_BITS]);

  always_comb begin
    legal_o = 1'b0;
    part_o  = '0;
    proc_o  = '0;
    unique case (quad)
      QD_USER: begin
        legal_o = 1'b1;
        part_o  = part_id_i;
        proc_o  = proc_id_i;
      end
      QD_OS: begin
        legal_o = 1'b1;
        part_o  = part_id_i;
        proc_o  = '0;  // OS space
      end
      default: legal_o = 1'b0;
    endcase
  end

  assign ea_o = {{QUAD_BITS{1'b0}}, ea_i[LOW_W-1:0]};
endmodule

// File: rtl/qd_out_stage.sv
module qd_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_pass
    assign q_o = d_i;
  end
endmodule

// File: rtl/addr_quadrant_dec.sv
module addr_quadrant_dec
  import qd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned ID_W    = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        access_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              ir_en_i,
  input  logic              dr_en_i,
  input  logic [ID_W-1:0]   part_id_i,
  input  logic [ID_W-1:0]   proc_id_i,
  output logic              valid_o,
  output logic              real_o,
  output logic              virt_o,
  output logic              seg_fault_o,
  output logic              seg_instr_o,
  output logic [2:0]        perm_o,
  output logic [ADDR_W-1:0] real_addr_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [ADDR_W-1:0] walk_ea_o,
  output logic [ID_W-1:0]   walk_part_o,
  output logic [ID_W-1:0]   walk_proc_o
);
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned PKT_W  = FLAG_W + PERM_W + 3*ADDR_W + 2*ID_W;
  localparam logic [ADDR_W-1:0] REAL_MASK = {ADDR_W{1'b1}} >> REAL_CLR_BITS;

  logic              is_fetch, is_real, q_legal;
  logic [ID_W-1:0]   q_part, q_proc;
  logic [ADDR_W-1:0] q_ea;

  qd_mode_sel u_mode (
    .access_i  (access_i),
    .ir_en_i   (ir_en_i),
    .dr_en_i   (dr_en_i),
    .is_fetch_o(is_fetch),
    .is_real_o (is_real)
  );

  qd_quadrant #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_quad (
    .ea_i     (ea_i),
    .part_id_i(part_id_i),
    .proc_id_i(proc_id_i),
    .legal_o  (q_legal),
    .part_o   (q_part),
    .proc_o   (q_proc),
    .ea_o     (q_ea)
  );

  logic              n_real, n_virt, n_seg, n_seg_i;
  logic [2:0]        n_perm;
  logic [ADDR_W-1:0] n_raddr, n_faddr, n_wea;
  logic [ID_W-1:0]   n_wpart, n_wproc;

  always_comb begin
    n_real  = valid_i & is_real;
    n_virt  = valid_i & ~is_real & q_legal;
    n_seg   = valid_i & ~is_real & ~q_legal;
    n_seg_i = n_seg & is_fetch;
    n_perm  = n_real ? 3'b111 : 3'b000;
    n_raddr = n_real ? (ea_i & REAL_MASK) : '0;
    n_faddr = (n_seg & ~is_fetch) ? ea_i : '0;
    n_wea   = n_virt ? q_ea   : '0;
    n_wpart = n_virt ? q_part : '0;
    n_wproc = n_virt ? q_proc : '0;
  end

  logic [PKT_W-1:0] pkt_d, pkt_q;
  assign pkt_d = {valid_i, n_real, n_virt, n_seg, n_seg_i, n_perm,
                  n_raddr, n_faddr, n_wea, n_wpart, n_wproc};

  qd_out_stage #(.W(PKT_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pkt_d),
    .q_o   (pkt_q)
  );

  assign {valid_o, real_o, virt_o, seg_fault_o, seg_instr_o, perm_o,
          real_addr_o, fault_addr_o, walk_ea_o, walk_part_o, walk_proc_o} = pkt_q;
endmodule

// File: rtl/qd_checker.sv
module qd_checker #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ID_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        access_i,
  input logic              valid_o,
  input logic              real_o,
  input logic              virt_o,
  input logic              seg_fault_o,
  input logic              seg_instr_o,
  input logic [2:0]        perm_o,
  input logic [ADDR_W-1:0] real_addr_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic [ADDR_W-1:0] walk_ea_o
);
  // R8
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({real_o, virt_o, seg_fault_o}) == 1);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(real_o || virt_o || seg_fault_o));
  // R2
  real_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    real_o |-> (perm_o == 3'b111) && (real_addr_o[ADDR_W-1 -: 4] == 4'h0) && !virt_o);
  // R7
  walk_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    virt_o |-> walk_ea_o[ADDR_W-1 -: 2] == 2'b00);
  // R6
  fault_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_instr_o || !seg_fault_o) |-> fault_addr_o == '0);
  // R5
  seg_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_instr_o |-> seg_fault_o);
  // R10
  access_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> access_i != 2'd3);
endmodule

bind addr_quadrant_dec qd_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .access_i    (access_i),
  .valid_o     (valid_o),
  .real_o      (real_o),
  .virt_o      (virt_o),
  .seg_fault_o (seg_fault_o),
  .seg_instr_o (seg_instr_o),
  .perm_o      (perm_o),
  .real_addr_o (real_addr_o),
  .fault_addr_o(fault_addr_o),
  .walk_ea_o   (walk_ea_o)
);

// File: tb/addr_quadrant_dec_tb.sv
module addr_quadrant_dec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  access_i = '0;
  logic [63:0] ea_i = '0;
  logic        ir_en_i = 1'b0, dr_en_i = 1'b0;
  logic [31:0] part_id_i = '0, proc_id_i = '0;
  logic        valid_o, real_o, virt_o, seg_fault_o, seg_instr_o;
  logic [2:0]  perm_o;
  logic [63:0] real_addr_o, fault_addr_o, walk_ea_o;
  logic [31:0] walk_part_o, walk_proc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // previous-cycle stimulus (model state)
  logic        p_v = 0, p_ir = 0, p_dr = 0;
  logic [1:0]  p_acc = 0;
  logic [63:0] p_ea = 0;
  logic [31:0] p_part = 0, p_proc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addr_quadrant_dec dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .access_i(access_i),
    .ea_i(ea_i), .ir_en_i(ir_en_i), .dr_en_i(dr_en_i),
    .part_id_i(part_id_i), .proc_id_i(proc_id_i),
    .valid_o(valid_o), .real_o(real_o), .virt_o(virt_o),
    .seg_fault_o(seg_fault_o), .seg_instr_o(seg_instr_o), .perm_o(perm_o),
    .real_addr_o(real_addr_o), .fault_addr_o(fault_addr_o),
    .walk_ea_o(walk_ea_o), .walk_part_o(walk_part_o), .walk_proc_o(walk_proc_o)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_model();
    bit rl, qok, fetch;
    logic [63:0] e_raddr, e_fa, e_wea;
    logic [31:0] e_wp, e_wq;
    fetch = (p_acc == 2);
    rl    = p_v && (fetch ? !p_ir : !p_dr);
    qok   = (p_ea[63:62] == 2'b00) || (p_ea[63:62] == 2'b11);
    e_raddr = rl ? (p_ea & 64'h0FFF_FFFF_FFFF_FFFF) : 64'h0;
    e_fa    = (p_v && !rl && !qok && !fetch) ? p_ea : 64'h0;
    e_wea   = (p_v && !rl && qok) ? (p_ea & 64'h3FFF_FFFF_FFFF_FFFF) : 64'h0;
    e_wp    = (p_v && !rl && qok) ? p_part : 32'h0;
    e_wq    = (p_v && !rl && p_ea[63:62] == 2'b00) ? p_proc : 32'h0;
    chk("R9", "valid_o", 64'(valid_o), 64'(p_v));
    chk("R1", "real_o", 64'(real_o), 64'(rl));
    chk("R2", "perm_o", 64'(perm_o), rl ? 64'd7 : 64'd0);
    chk("R2", "real_addr_o", real_addr_o, e_raddr);
    chk("R8", "virt_o", 64'(virt_o), 64'(p_v && !rl && qok));
    chk("R5", "seg_fault_o", 64'(seg_fault_o), 64'(p_v && !rl && !qok));
    chk("R5", "seg_instr_o", 64'(seg_instr_o), 64'(p_v && !rl && !qok && fetch));
    chk("R6", "fault_addr_o", fault_addr_o, e_fa);
    chk("R7", "walk_ea_o", walk_ea_o, e_wea);
    chk("R3", "walk_part_o", 64'(walk_part_o), 64'(e_wp));
    chk("R4", "walk_proc_o", 64'(walk_proc_o), 64'(e_wq));
  endtask

  task automatic step(bit v, logic [1:0] acc, logic [63:0] ea, bit ir, bit dr,
                      logic [31:0] pt, logic [31:0] pc);
    @(negedge clk_i);
    check_model();
    valid_i = v; access_i = acc; ea_i = ea; ir_en_i = ir; dr_en_i = dr;
    part_id_i = pt; proc_id_i = pc;
    p_v = v; p_acc = acc; p_ea = ea; p_ir = ir; p_dr = dr; p_part = pt; p_proc = pc;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9", "valid_o reset", 64'(valid_o), 0);
    chk("R9", "real_addr_o reset", real_addr_o, 0);
    chk("R9", "walk_ea_o reset", walk_ea_o, 0);
    rst_ni = 1'b1;
    for (int a = 0; a < 3; a++)
      for (int q = 0; q < 4; q++)
        for (int en = 0; en < 4; en++)
          step(1'b1, 2'(a), {2'(q), 62'h0ABC_DEF0_1234_5678 + 62'(a*16 + en)},
               en[1], en[0], 32'h5A00_0000 + 32'(q), 32'hC300_0100 + 32'(a));
    step(1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 32'h1, 32'h2);
    for (int i = 0; i < 300; i++)
      step(($urandom % 4) != 0, 2'($urandom % 3), {$urandom, $urandom},
           1'($urandom), 1'($urandom), $urandom, $urandom);
    step(1'b0, 2'd0, 64'h0, 1'b0, 1'b0, 32'h0, 32'h0);
    step(1'b0, 2'd0, 64'h0, 1'b0, 1'b0, 32'h0, 32'h0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule